// File: doc/BRIEF.md
# Receive Byte Queue with Trigger Flags

This block is the receive-side storage of a UART-style serial controller. The serial shifter offers at most one received byte per frame tick; the block stores it in a 16-deep queue, and a processor register port removes bytes one at a time from the head. The number of stored bytes is always visible as a 5-bit count running from 0 to 16.

Two receive flags tell software when to read. The full flag rises once the count reaches a level picked by a 2-bit selector from a fixed, non-linear set. The ready flag covers a short burst that never reaches that level: it rises after two frame ticks pass with no arrival while bytes are waiting. A byte that arrives with no room is dropped and sets a sticky overrun bit, and reception stops until software clears it. A receive interrupt line and an error interrupt line follow these flags, each under its own enable. A flush strobe empties the queue.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset the count is 0 and flagRdf, flagDr, overrun, rxIrq and errIrq are all 0.
- R2: An accepted byte is a cycle with frameTick=1, rxValid=1, rxEn=1 and overrun=0. It raises count by one at that clock edge. popReq on a non-empty queue lowers count by one at that edge. popData always shows the oldest stored byte, and bytes leave in the order they arrived.
- R3: An accepted byte and a pop in the same cycle both take effect and leave the count unchanged, even when the count is 16. No overrun results.
- R4: A byte offered while the count is 16 and no pop happens is dropped. The count stays 16 and overrun is 1 after that edge.
- R5: While overrun is 1 or rxEn is 0, offered bytes are ignored and the count does not change. ovrClr returns overrun to 0.
- R6: trigSel selects the full level: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. flagRdf becomes 1 on the edge after the one at which count first reaches the level.
- R7: flagClr lowers flagRdf only when count is below the level in that cycle; otherwise flagRdf stays 1. flagClr always lowers flagDr.
- R8: flagDr is set on a frameTick cycle with no accepted byte, when the previous frameTick also had no accepted byte and 0 < count < level. A tick that directly follows an arrival tick does not set it.
- R9: While rxIrqEn is 1, rxIrq takes the value of (flagDr OR flagRdf) from the previous cycle. While rxIrqEn is 0, rxIrq holds its value.
- R10: While rxIrqEn or errIrqEn is 1, errIrq takes the previous cycle's overrun. While both are 0, errIrq holds its value.
- R11: fifoReset empties the queue, so count is 0 after the edge. It clears flagDr and flagRdf and overrides a pop or an arrival in the same cycle. It leaves overrun unchanged.
- R12: popReq on an empty queue has no effect; the count stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameTick | input | 1 | One-cycle strobe per serial frame time |
| rxValid | input | 1 | A received byte is offered in this tick |
| rxByte | input | 8 | Received byte |
| rxEn | input | 1 | Reception enable |
| popReq | input | 1 | Remove the head byte |
| popData | output | 8 | Oldest stored byte |
| trigSel | input | 2 | Full-level selector (1, 4, 8, 14) |
| fifoReset | input | 1 | Flush the queue and clear the receive flags |
| flagClr | input | 1 | Software clear of flagDr and, if allowed, flagRdf |
| ovrClr | input | 1 | Clear the overrun bit |
| rxIrqEn | input | 1 | Receive interrupt enable |
| errIrqEn | input | 1 | Error interrupt enable |
| count | output | 5 | Stored byte count, 0 to 16 |
| flagRdf | output | 1 | Count has reached the selected level |
| flagDr | output | 1 | Data waiting after an idle gap |
| overrun | output | 1 | Sticky overrun bit |
| rxIrq | output | 1 | Receive interrupt |
| errIrq | output | 1 | Error interrupt |

## Verification
An arriving byte and a processor pop can land in the same clock cycle. This matters most when the queue holds all 16 entries, where the write has to use the slot the pop frees rather than count as an overrun. The bench fills the queue with one arrival per cycle, then offers a byte together with a pop. It expects the count to stay at 16, overrun to stay low, and the head to advance to the second byte. A partly filled queue gets the same overlap from the vector table. A flush is also issued together with a pop to show that the flush wins.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Strobes from control to storage
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } rxqStrobe_t;

  // Full levels indexed by the 2-bit selector
  localparam int unsigned TRIG_LEVELS [4] = '{1, 4, 8, 14};

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxqStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.flush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop)  rdPtr <= bump(rdPtr);
      count <= count + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
    end
  end

  assign rdData = mem[rdPtr];

  // R4: never written past capacity unless a slot is freed in the same cycle
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (count < CNT_W'(DEPTH) || strobe.pop));

  // R12: a pop is only issued when something is stored
  p_pop_nonempty_r12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> (count != '0));

  // R3: push with pop keeps the count
  p_pushpop_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && strobe.pop && !strobe.flush) |=> $stable(count));

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameTick,
  input  logic             rxValid,
  input  logic             rxEn,
  input  logic             popReq,
  input  logic [1:0]       trigSel,
  input  logic             fifoReset,
  input  logic             flagClr,
  input  logic             ovrClr,
  input  logic             rxIrqEn,
  input  logic             errIrqEn,
  input  logic [CNT_W-1:0] count,
  output rxqStrobe_t       strobe,
  output logic             flagRdf,
  output logic             flagDr,
  output logic             overrun,
  output logic             rxIrq,
  output logic             errIrq
);

  logic [CNT_W-1:0] trigLevel;
  logic isEmpty;
  logic isFull;
  logic arriveNow;
  logic arrivedPrev;
  logic popOk;
  logic pushOk;
  logic dropNow;
  logic drSet;
  logic rdfSet;

  always_comb begin
    trigLevel = CNT_W'(TRIG_LEVELS[trigSel]);
    isEmpty   = (count == '0);
    isFull    = (count == CNT_W'(DEPTH));
    arriveNow = frameTick && rxValid && rxEn && !overrun;
    popOk     = popReq && !isEmpty && !fifoReset;
    pushOk    = arriveNow && (!isFull || popOk) && !fifoReset;
    dropNow   = arriveNow && isFull && !popOk && !fifoReset;
    drSet     = frameTick && !arriveNow && !arrivedPrev && !isEmpty &&
                (count < trigLevel);
    rdfSet    = (count >= trigLevel);
    strobe.push  = pushOk;
    strobe.pop   = popOk;
    strobe.flush = fifoReset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) arrivedPrev <= 1'b0;
    else if (frameTick) arrivedPrev <= arriveNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            flagRdf <= 1'b0;
    else if (fifoReset)   flagRdf <= 1'b0;
    else if (rdfSet)      flagRdf <= 1'b1;
    else if (flagClr)     flagRdf <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            flagDr <= 1'b0;
    else if (fifoReset)   flagDr <= 1'b0;
    else if (drSet)       flagDr <= 1'b1;
    else if (flagClr)     flagDr <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            overrun <= 1'b0;
    else if (dropNow)     overrun <= 1'b1;
    else if (ovrClr)      overrun <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rxIrq <= 1'b0;
    else if (rxIrqEn) rxIrq <= flagDr || flagRdf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    errIrq <= 1'b0;
    else if (rxIrqEn || errIrqEn) errIrq <= overrun;
  end

  // R5: no storage write while overrun is pending
  p_ovr_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> !strobe.push);

  // R4: a dropped byte leaves the queue full and overrun set
  p_drop_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    dropNow |=> (count == CNT_W'(DEPTH) && overrun));

  // R11: flush empties and clears both receive flags
  p_flush_r11: assert property (@(posedge clk) disable iff (!rstN)
    fifoReset |=> (count == '0 && !flagDr && !flagRdf));

  // R8: an arrival tick never raises the ready flag at its edge
  p_dr_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    arriveNow |=> !$rose(flagDr));

  // R9: receive interrupt frozen while disabled
  p_rxirq_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rxIrqEn |=> $stable(rxIrq));

  // R10: error interrupt mirrors overrun while enabled
  p_errirq_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxIrqEn || errIrqEn) |=> (errIrq == $past(overrun)));

endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameTick,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxEn,
  input  logic              popReq,
  output logic [DATA_W-1:0] popData,
  input  logic [1:0]        trigSel,
  input  logic              fifoReset,
  input  logic              flagClr,
  input  logic              ovrClr,
  input  logic              rxIrqEn,
  input  logic              errIrqEn,
  output logic [CNT_W-1:0]  count,
  output logic              flagRdf,
  output logic              flagDr,
  output logic              overrun,
  output logic              rxIrq,
  output logic              errIrq
);

  rxqStrobe_t strobe;

  rxq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .rxValid(rxValid),
    .rxEn(rxEn), .popReq(popReq), .trigSel(trigSel), .fifoReset(fifoReset),
    .flagClr(flagClr), .ovrClr(ovrClr), .rxIrqEn(rxIrqEn),
    .errIrqEn(errIrqEn), .count(count), .strobe(strobe),
    .flagRdf(flagRdf), .flagDr(flagDr), .overrun(overrun),
    .rxIrq(rxIrq), .errIrq(errIrq)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(rxByte),
    .rdData(popData), .count(count)
  );

endmodule

// File: tb/sim_rx_trig_fifo.sv
`timescale 1ns/1ps
module sim_rx_trig_fifo;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameTick = 0, rxValid = 0, rxEn = 0, popReq = 0;
  logic [7:0] rxByte = '0;
  logic [1:0] trigSel = 2'd3;
  logic fifoReset = 0, flagClr = 0, ovrClr = 0, rxIrqEn = 0, errIrqEn = 0;
  logic [7:0] popData;
  logic [4:0] count;
  logic flagRdf, flagDr, overrun, rxIrq, errIrq;

  int nChk = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  rx_trig_fifo u0 (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .rxValid(rxValid),
    .rxByte(rxByte), .rxEn(rxEn), .popReq(popReq), .popData(popData),
    .trigSel(trigSel), .fifoReset(fifoReset), .flagClr(flagClr),
    .ovrClr(ovrClr), .rxIrqEn(rxIrqEn), .errIrqEn(errIrqEn),
    .count(count), .flagRdf(flagRdf), .flagDr(flagDr), .overrun(overrun),
    .rxIrq(rxIrq), .errIrq(errIrq)
  );

  // rows: {tick/valid, byte, pop, expected count, expected head}
  localparam int NV = 11;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 8'hA0, 1'b0, 5'd1, 8'hA0},
    {1'b1, 8'hA1, 1'b0, 5'd2, 8'hA0},
    {1'b1, 8'hA2, 1'b0, 5'd3, 8'hA0},
    {1'b0, 8'h00, 1'b1, 5'd2, 8'hA1},
    {1'b1, 8'hA3, 1'b1, 5'd2, 8'hA2},
    {1'b0, 8'h00, 1'b1, 5'd1, 8'hA3},
    {1'b0, 8'h00, 1'b1, 5'd0, 8'h00},
    {1'b0, 8'h00, 1'b1, 5'd0, 8'h00},
    {1'b1, 8'hB0, 1'b0, 5'd1, 8'hB0},
    {1'b1, 8'hB1, 1'b1, 5'd1, 8'hB1},
    {1'b0, 8'h00, 1'b1, 5'd0, 8'h00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: drive pulses, wait for the edge, return to idle
  task automatic cyc(input logic tk, input logic vld, input logic [7:0] b,
                     input logic pp, input logic rs, input logic fc,
                     input logic oc);
    frameTick = tk; rxValid = vld; rxByte = b; popReq = pp;
    fifoReset = rs; flagClr = fc; ovrClr = oc;
    @(negedge clk);
    frameTick = 0; rxValid = 0; popReq = 0;
    fifoReset = 0; flagClr = 0; ovrClr = 0;
  endtask

  task automatic idle();
    cyc(0, 0, 8'h00, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 flags", {flagRdf, flagDr, overrun, rxIrq, errIrq}, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 count after release", count, 0);
    rxEn = 1;
    trigSel = 2'd3;

    // table: order, count, overlap, empty pop (R2, R3, R12)
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][22], VEC[i][22], VEC[i][21:14], VEC[i][13], 0, 0, 0);
      chk($sformatf("R2/R3/R12 row%0d count", i), count, VEC[i][12:8]);
      if (VEC[i][12:8] != 0)
        chk($sformatf("R2 row%0d head", i), popData, VEC[i][7:0]);
    end

    // fill to capacity
    for (int i = 0; i < 16; i++) cyc(1, 1, 8'(8'h10 + i), 0, 0, 0, 0);
    chk("R2 full count", count, 16);
    chk("R2 full head", popData, 8'h10);
    chk("R6 rdf at 16 sel3", flagRdf, 1);
    cyc(1, 1, 8'h55, 1, 0, 0, 0);
    chk("R3 full push+pop count", count, 16);
    chk("R3 no overrun", overrun, 0);
    chk("R3 head advanced", popData, 8'h11);
    cyc(1, 1, 8'h66, 0, 0, 0, 0);
    chk("R4 drop count", count, 16);
    chk("R4 overrun set", overrun, 1);
    idle();
    chk("R10 errIrq holds while disabled", errIrq, 0);
    errIrqEn = 1;
    idle();
    chk("R10 errIrq follows overrun", errIrq, 1);
    cyc(1, 1, 8'h77, 1, 0, 0, 0);
    chk("R5 arrival ignored under overrun", count, 15);
    cyc(1, 1, 8'h88, 1, 1, 0, 0);
    chk("R11 flush count", count, 0);
    chk("R11 flush rdf", flagRdf, 0);
    chk("R11 overrun kept", overrun, 1);
    cyc(0, 0, 8'h00, 0, 0, 0, 1);
    chk("R5 ovrClr", overrun, 0);
    idle();
    chk("R10 errIrq drops", errIrq, 0);
    errIrqEn = 0;
    rxEn = 0;
    cyc(1, 1, 8'h99, 0, 0, 0, 0);
    chk("R5 rxEn low ignored", count, 0);
    rxEn = 1;

    // trigger levels (R6)
    for (int s = 0; s < 4; s++) begin
      int lvl;
      lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
      trigSel = 2'(s);
      cyc(0, 0, 8'h00, 0, 1, 0, 0);
      for (int k = 0; k < lvl - 1; k++) cyc(1, 1, 8'(k), 0, 0, 0, 0);
      idle();
      chk($sformatf("R6 sel%0d below level", s), flagRdf, 0);
      cyc(1, 1, 8'hEE, 0, 0, 0, 0);
      idle();
      chk($sformatf("R6 sel%0d at level", s), flagRdf, 1);
    end

    // RDF clear rule (R7), sel3 with 14 stored
    cyc(0, 0, 8'h00, 0, 0, 1, 0);
    chk("R7 clear refused at level", flagRdf, 1);
    cyc(0, 0, 8'h00, 1, 0, 0, 0);
    cyc(0, 0, 8'h00, 0, 0, 1, 0);
    chk("R7 clear below level", flagRdf, 0);

    // ready flag idle timeout (R8) and receive interrupt (R9)
    cyc(0, 0, 8'h00, 0, 1, 0, 0);
    rxIrqEn = 1;
    idle();
    chk("R9 irq low with no flags", rxIrq, 0);
    cyc(1, 1, 8'h42, 0, 0, 0, 0);
    cyc(1, 0, 8'h00, 0, 0, 0, 0);
    chk("R8 no dr right after arrival", flagDr, 0);
    cyc(1, 0, 8'h00, 0, 0, 0, 0);
    chk("R8 dr after two quiet ticks", flagDr, 1);
    idle();
    chk("R9 irq follows dr", rxIrq, 1);
    rxIrqEn = 0;
    cyc(0, 0, 8'h00, 0, 0, 1, 0);
    chk("R7 flagClr drops dr", flagDr, 0);
    idle();
    chk("R9 irq holds while disabled", rxIrq, 1);
    rxIrqEn = 1;
    idle();
    chk("R9 irq clears when enabled", rxIrq, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule